// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

This block is a parameterised general-purpose I/O controller that sits on a simple single-cycle register bus (word address, write strobe, write data and combinational read data). Each I/O line has an output value held in an output latch and an output-enable taken from a single direction state. The pin inputs reach the read path through a two-flop synchroniser. The number of lines equals the register width, which may be 8, 16, 32 or 64 bits.

Software can change the output latch in three ways: it can load the whole word, it can write ones to raise chosen lines, or it can write ones to lower chosen lines. Direction can be programmed from either polarity. One register views a 1 as "output" and the other views a 1 as "input". Both registers act on the same direction state, so each always reads back as the bitwise complement of the other. A build-time option reverses the line-to-bit order, so that line n sits at register bit WIDTH-1-n in every register. The pins themselves stay in line order.

Register word addresses (bus_addr), which the software view depends on: 0 = level/load register, 1 = raise register, 2 = lower register, 3 = output-direction register, 4 = input-direction register. Addresses 5 to 7 are unmapped.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and right after it, every line is an input (pin_oe all zero), the output latch is all zero (pin_out all zero), address 3 reads zero and address 4 reads all ones.
- R2: A write to address 0 loads the whole write word into the output latch in one clock, and the new value appears on pin_out after that edge.
- R3: A write to address 1 sets each latch bit whose write bit is 1. Latch bits whose write bit is 0 keep their value.
- R4: A write to address 2 clears each latch bit whose write bit is 1. Latch bits whose write bit is 0 keep their value.
- R5: A write to address 3 makes every line whose bit is 1 an output (pin_oe high) and every line whose bit is 0 an input.
- R6: A write to address 4 makes every line whose bit is 1 an input and every line whose bit is 0 an output. Address 3 and address 4 always read back as bitwise complements.
- R7: Reading address 0 returns the latch bit for output lines and the synchronised pin level for input lines.
- R8: A pin change reaches the address-0 read value after exactly two rising clock edges.
- R9: Reading address 1 returns the output latch contents, whatever the line directions are.
- R10: With MIRROR=1, line n maps to bit WIDTH-1-n of every register for both writes and reads. With MIRROR=0, line n maps to bit n.
- R11: Address 2 and the unmapped addresses 5 to 7 read as zero. Writes to addresses 5 to 7 leave the latch and the direction state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| pin_in | input | WIDTH | Asynchronous pin levels, line order |
| pin_out | output | WIDTH | Output latch, line order |
| pin_oe | output | WIDTH | Output enable per line, line order |

## Verification
An 8-bit straight instance and an 8-bit mirrored instance share one stimulus. Every one of the 256 direction words is written through each direction register, which separates true bit-to-line mapping and complementing from stuck, swapped or unreversed bits. Load, raise and lower are applied in sequence with three arithmetically unrelated operands per sweep step, so an operation that leaks into zero bits or fails to act on one bits shows up. The mixed-direction level read uses independent direction, latch and pin words, which tells whether a source was chosen per line or per word. A single pin step followed over two edges pins down the synchroniser depth exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word-address width of the register bus.
  localparam int unsigned REG_AW = 3;

  // Register word addresses.
  typedef enum logic [REG_AW-1:0] {
    RS_LEVEL = 3'd0,
    RS_RAISE = 3'd1,
    RS_LOWER = 3'd2,
    RS_DOUT  = 3'd3,
    RS_DIN   = 3'd4
  } reg_sel_e;

  // Highest mapped address; anything above reads zero.
  localparam logic [REG_AW-1:0] RS_LAST = RS_DIN;

endpackage

// File: rtl/gpio_lane_map.sv
// Reorders a word between bus bit order and line order.
module gpio_lane_map #(
  parameter int unsigned WIDTH  = 32,
  parameter bit          MIRROR = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    if (MIRROR) begin : g_rev
      assign dout[i] = din[WIDTH-1-i];
    end else begin : g_str
      assign dout[i] = din[i];
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the pin inputs.
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  // Edges seen since reset, saturating, so the latency check never looks into reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && age_q >= 2'd2) |-> (pin_sync == $past(pin_in, 2)))
    else $error("synchroniser latency wrong");

endmodule

// File: rtl/gpio_core_regs.sv
// Output latch and the single direction state, both in line order.
module gpio_core_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_level,
  input  logic             wr_raise,
  input  logic             wr_lower,
  input  logic             wr_dout,
  input  logic             wr_din,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);

  // New latch value: load, then raise, then lower, so lowering dominates.
  function automatic logic [WIDTH-1:0] latch_update(
    input logic [WIDTH-1:0] old_v,
    input logic [WIDTH-1:0] v,
    input logic             ld,
    input logic             st,
    input logic             cl
  );
    logic [WIDTH-1:0] r;
    r = old_v;
    if (ld) r = v;
    if (st) r = r | v;
    if (cl) r = r & ~v;
    return r;
  endfunction

  // New direction value: 1 = output. The input-direction view is inverted.
  function automatic logic [WIDTH-1:0] dir_update(
    input logic [WIDTH-1:0] old_v,
    input logic [WIDTH-1:0] v,
    input logic             as_out,
    input logic             as_in
  );
    logic [WIDTH-1:0] r;
    r = old_v;
    if (as_out) r = v;
    if (as_in)  r = ~v;
    return r;
  endfunction

  logic [WIDTH-1:0] latch_nxt;
  logic [WIDTH-1:0] dir_nxt;
  logic             latch_touch;
  logic             dir_touch;

  assign latch_touch = wr_level | wr_raise | wr_lower;
  assign dir_touch   = wr_dout | wr_din;

  always_comb begin
    latch_nxt = latch_update(latch_q, wval, wr_level, wr_raise, wr_lower);
    dir_nxt   = dir_update(dir_q, wval, wr_dout, wr_din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (latch_touch) latch_q <= latch_nxt;
      if (dir_touch)   dir_q   <= dir_nxt;
    end
  end

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level |=> (latch_q == $past(wval)))
    else $error("load did not take");

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_touch |=> $stable(latch_q))
    else $error("latch moved without write");

  // R3
  raise_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raise |=> (((latch_q & $past(wval)) == $past(wval)) &&
                  (((latch_q ^ $past(latch_q)) & ~$past(wval)) == '0)))
    else $error("raise write wrong");

  // R4
  lower_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lower |=> (((latch_q & $past(wval)) == '0) &&
                  (((latch_q ^ $past(latch_q)) & ~$past(wval)) == '0)))
    else $error("lower write wrong");

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_touch |=> $stable(dir_q))
    else $error("direction moved without write");

  // R6
  din_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_din |=> (dir_q == ~$past(wval)))
    else $error("input-direction write not inverted");

endmodule

// File: rtl/gpio_rd_select.sv
// Read-back selection in line order.
module gpio_rd_select
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] sel,
  input  logic [WIDTH-1:0]  latch_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rd_line
);

  // Per-line level: the latch for outputs, the synchronised pin for inputs.
  function automatic logic [WIDTH-1:0] line_level(
    input logic [WIDTH-1:0] dir,
    input logic [WIDTH-1:0] lat,
    input logic [WIDTH-1:0] pin
  );
    return (dir & lat) | (~dir & pin);
  endfunction

  always_comb begin
    unique case (sel)
      RS_LEVEL: rd_line = line_level(dir_q, latch_q, pin_sync);
      RS_RAISE: rd_line = latch_q;
      RS_DOUT:  rd_line = dir_q;
      RS_DIN:   rd_line = ~dir_q;
      default:  rd_line = '0;
    endcase
  end

  // R7
  level_out_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == RS_LEVEL) |-> (((rd_line ^ latch_q) & dir_q) == '0))
    else $error("output line read-back differs from latch");

  // R7
  level_in_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == RS_LEVEL) |-> (((rd_line ^ pin_sync) & ~dir_q) == '0))
    else $error("input line read-back differs from pin");

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > RS_LAST || sel == RS_LOWER) |-> (rd_line == '0))
    else $error("unmapped or lower register read non-zero");

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter bit          MIRROR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  initial begin
    width_ok_chk: assert (WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)
      else $error("register width must be 8, 16, 32 or 64");
  end

  // Decoded write events, named for the checks.
  logic wr_level_hit, wr_raise_hit, wr_lower_hit, wr_dout_hit, wr_din_hit;
  assign wr_level_hit = bus_wr && (bus_addr == RS_LEVEL);
  assign wr_raise_hit = bus_wr && (bus_addr == RS_RAISE);
  assign wr_lower_hit = bus_wr && (bus_addr == RS_LOWER);
  assign wr_dout_hit  = bus_wr && (bus_addr == RS_DOUT);
  assign wr_din_hit   = bus_wr && (bus_addr == RS_DIN);

  logic [WIDTH-1:0] wval_line;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_line;

  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wmap (
    .din  (bus_wdata),
    .dout (wval_line)
  );

  gpio_core_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_level (wr_level_hit),
    .wr_raise (wr_raise_hit),
    .wr_lower (wr_lower_hit),
    .wr_dout  (wr_dout_hit),
    .wr_din   (wr_din_hit),
    .wval     (wval_line),
    .latch_q  (latch_q),
    .dir_q    (dir_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_rd_select #(.WIDTH(WIDTH)) u_rsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_addr),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rd_line  (rd_line)
  );

  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rmap (
    .din  (rd_line),
    .dout (bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > RS_LAST) |=> ($stable(pin_out) && $stable(pin_oe)))
    else $error("unmapped write changed state");

  // R5
  dout_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout_hit |=> (pin_oe == $past(wval_line)))
    else $error("output-direction write not on pin_oe");

endmodule

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] rdata, rdata_m, pout, pout_m, poe, poe_m;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.WIDTH(W), .MIRROR(1'b0)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .pin_in(pin_in),
    .pin_out(pout), .pin_oe(poe));

  gpio_bank #(.WIDTH(W), .MIRROR(1'b1)) i_gpio_bank_m (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .pin_in(pin_in),
    .pin_out(pout_m), .pin_oe(poe_m));

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", poe, '0);
    chk("R1 out in reset", pout, '0);
    rst_n = 1'b1;
    rd(3'd3); chk("R1 dout reads 0", rdata, '0); chk("R1 dout reads 0 m", rdata_m, '0);
    rd(3'd4); chk("R1 din reads ones", rdata, '1); chk("R1 din reads ones m", rdata_m, '1);
    rd(3'd1); chk("R1 latch zero", rdata, '0);
    chk("R1 oe after reset", poe, '0);

    // R5 R6 R10 direction sweep
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] d;
      d = v[W-1:0];
      wr(3'd3, d);
      chk("R5 pin_oe", poe, d);
      chk("R10 pin_oe mirrored", poe_m, rev(d));
      rd(3'd4);
      chk("R6 din complement", rdata, ~d);
      chk("R6 din complement m", rdata_m, ~d);
      wr(3'd4, d);
      chk("R6 din write", poe, ~d);
      chk("R10 din write mirrored", poe_m, rev(~d));
      rd(3'd3);
      chk("R6 dout complement", rdata, ~d);
    end

    // R2 R3 R4 R9 latch sweep
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] a, b, c;
      a = v[W-1:0];
      b = 8'((v * 37 + 11) & 255);
      c = 8'((v * 101 + 3) & 255);
      wr(3'd0, a);
      chk("R2 load", pout, a);
      chk("R10 load mirrored", pout_m, rev(a));
      rd(3'd1);
      chk("R9 raise reg readback", rdata, a);
      chk("R9 raise reg readback m", rdata_m, a);
      wr(3'd1, b);
      chk("R3 raise", pout, a | b);
      chk("R3 raise m", pout_m, rev(a | b));
      wr(3'd2, c);
      chk("R4 lower", pout, (a | b) & ~c);
      chk("R4 lower m", pout_m, rev((a | b) & ~c));
    end

    // R7 mixed directions
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] d, l, p;
      d = v[W-1:0];
      l = 8'((v * 53 + 7) & 255);
      p = 8'((v * 29 + 200) & 255);
      @(negedge clk); pin_in = p;
      wr(3'd3, d);
      wr(3'd0, l);
      rd(3'd0);
      chk("R7 level read", rdata, (d & l) | (~d & p));
      chk("R7 level read m", rdata_m, (d & l) | (~d & rev(p)));
    end

    // R8 synchroniser latency
    wr(3'd3, '0);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_addr = 3'd0; pin_in = 8'hA5;
    @(negedge clk); #1;
    chk("R8 one edge old", rdata, 8'h00);
    @(negedge clk); #1;
    chk("R8 two edges new", rdata, 8'hA5);
    chk("R8 two edges new m", rdata_m, 8'hA5);

    // R10 single-bit mapping
    wr(3'd3, 8'h01);
    chk("R10 bit0 straight", poe, 8'h01);
    chk("R10 bit0 mirrored", poe_m, 8'h80);

    // R11 unmapped and lower register
    wr(3'd0, 8'h3C);
    wr(3'd3, 8'hF0);
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF);
      chk("R11 stray write latch", pout, 8'h3C);
      chk("R11 stray write dir", poe, 8'hF0);
      chk("R11 stray write latch m", pout_m, rev(8'h3C));
      rd(a[2:0]);
      chk("R11 unmapped read", rdata, '0);
      chk("R11 unmapped read m", rdata_m, '0);
    end
    rd(3'd2);
    chk("R11 lower reads zero", rdata, '0);

    finish_run();
  end

endmodule